// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block services one cache miss at a time for a 64-byte line that memory returns as four 16-byte chunks. When a miss is accepted it issues a single memory request together with the index of the chunk that memory should send first. It then tags every arriving chunk with its position in the line and holds it in a small buffer. From that buffer it writes the chunks into the cache data array through a write port that takes at most one chunk every four cycles. It also captures the chunk that holds the missed byte and hands it back to the requester.

A mode input, sampled when the miss is accepted, chooses between two policies. In critical-first mode the burst starts at the chunk that holds the missed byte and wraps around the line, for example 2, 3, 0, 1. The requester is released the cycle after that chunk arrives, while the rest of the line is still being written. In in-order mode the burst starts at chunk 0, and the requester is released only once the last chunk has been written into the array. In both modes a line-valid flag marks the point where the whole line is present in the array.

Top module: `rfl_refill_seq`

## Requirements
- R1: After reset, mem_req, arr_we, restart_valid, line_valid and busy are all 0.
- R2: A miss_req seen while busy is 0 is accepted. mem_req is 1 for exactly the one cycle after it. mem_start then carries miss_off[5:4] when cwf_mode was 1, or 0 when cwf_mode was 0. busy is 1 from that cycle on.
- R3: The k-th chunk that arrives after a request (k = 0..3) belongs to line position (mem_start + k) mod 4. It is written to the array with arr_idx equal to that position and arr_wdata equal to its data. Every chunk is written exactly once.
- R4: Successive array writes are at least 4 cycles apart. Chunk k arrives on the clock edge where mem_valid is sampled. Its write (arr_we high) appears max(1 cycle after that edge, 4 cycles after the previous write), so no chunk is lost when arrivals come faster than the write rate.
- R5: In critical-first mode, restart_valid is 1 in the cycle after the critical chunk arrives, and restart_data holds that chunk.
- R6: In in-order mode, restart_valid is 1 in the cycle after the fourth array write, and restart_data holds the chunk whose position equals miss_off[5:4].
- R7: line_valid rises in the cycle after the fourth array write and stays 1 until the cycle after the next accepted miss, when it is 0.
- R8: restart_valid is a one-cycle pulse, issued exactly once per accepted miss.
- R9: A miss_req seen while busy is 1 causes no memory request. A mem_valid seen while busy is 0 causes no array write and leaves line_valid unchanged.
- R10: busy falls in the same cycle that line_valid rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | Start a refill (taken only when idle) |
| miss_off | input | 6 | Byte offset of the missed access within the line |
| cwf_mode | input | 1 | 1: critical-first with early restart, 0: in-order refill |
| mem_req | output | 1 | One-cycle request to memory |
| mem_start | output | 2 | Chunk index memory must send first |
| mem_valid | input | 1 | A returning chunk is present on mem_data |
| mem_data | input | 128 | Returning chunk data |
| arr_we | output | 1 | Data array chunk write strobe |
| arr_idx | output | 2 | Chunk position written |
| arr_wdata | output | 128 | Chunk data written |
| restart_valid | output | 1 | One-cycle release of the requester |
| restart_data | output | 128 | Chunk holding the missed byte |
| line_valid | output | 1 | Whole line present in the array |
| busy | output | 1 | A refill is in progress |

## Verification
The delicate overlap is a chunk entering the holding buffer in the same cycle that an older chunk leaves it for the throttled write port. A second overlap is the in-order release landing in the same cycle as line_valid and the fall of busy. The first is provoked by sweeping every mode and critical index with memory driven back to back, at a three-cycle spacing and at the nominal 120/16 timing. For each case the bench computes every write cycle as the larger of the arrival cycle plus one and the previous write cycle plus four, and compares index, data and cycle. The second is judged by requiring restart_valid and line_valid to appear together exactly one cycle after the computed last write.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  typedef enum logic {
    RFL_INORDER = 1'b0,
    RFL_CRIT    = 1'b1
  } rfl_mode_e;

  // position of the k-th delivered chunk for a given burst start
  function automatic int unsigned rfl_wrap(int unsigned start, int unsigned k, int unsigned n);
    return (start + k) % n;
  endfunction
endpackage

// File: rtl/rfl_chunk_fifo.sv
module rfl_chunk_fifo #(
  parameter int W     = 130,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         avail
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign dout  = mem[rp];
  assign avail = (cnt != '0);
endmodule

// File: rtl/rfl_wr_port.sv
module rfl_wr_port #(
  parameter int CHUNK_W = 128,
  parameter int IDX_W   = 2,
  parameter int WR_GAP  = 4,
  localparam int CW     = $clog2(WR_GAP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               avail,
  input  logic [IDX_W-1:0]   head_idx,
  input  logic [CHUNK_W-1:0] head_data,
  output logic               pop,
  output logic               arr_we,
  output logic [IDX_W-1:0]   arr_idx,
  output logic [CHUNK_W-1:0] arr_wdata
);
  logic [CW-1:0] cool;

  assign pop = avail && (cool == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cool      <= '0;
      arr_we    <= 1'b0;
      arr_idx   <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we <= pop;
      if (pop) begin
        arr_idx   <= head_idx;
        arr_wdata <= head_data;
        cool      <= CW'(WR_GAP - 1);
      end else if (cool != '0) begin
        cool <= cool - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfl_refill_seq.sv
module rfl_refill_seq #(
  parameter int CHUNK_BYTES = 16,
  parameter int CHUNKS      = 4,
  parameter int WR_GAP      = 4,
  localparam int CHUNK_W    = CHUNK_BYTES * 8,
  localparam int OFF_W      = $clog2(CHUNK_BYTES * CHUNKS),
  localparam int IDX_W      = $clog2(CHUNKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_req,
  input  logic [OFF_W-1:0]   miss_off,
  input  logic               cwf_mode,
  output logic               mem_req,
  output logic [IDX_W-1:0]   mem_start,
  input  logic               mem_valid,
  input  logic [CHUNK_W-1:0] mem_data,
  output logic               arr_we,
  output logic [IDX_W-1:0]   arr_idx,
  output logic [CHUNK_W-1:0] arr_wdata,
  output logic               restart_valid,
  output logic [CHUNK_W-1:0] restart_data,
  output logic               line_valid,
  output logic               busy
);
  import rfl_pkg::*;

  localparam int EW = IDX_W + CHUNK_W;

  logic [IDX_W-1:0]   crit_q, start_q, in_idx, off_idx, head_idx;
  rfl_mode_e          mode_q;
  logic [IDX_W:0]     rx_cnt, wr_cnt;
  logic [CHUNK_W-1:0] crit_data, head_data;
  logic               accept, arrive, pop, avail, last_wr;
  logic [EW-1:0]      head;

  assign off_idx = miss_off[OFF_W-1 -: IDX_W];
  assign accept  = miss_req && !busy;
  assign arrive  = mem_valid && busy && (rx_cnt != (IDX_W+1)'(CHUNKS));
  assign in_idx  = start_q + rx_cnt[IDX_W-1:0];
  assign head_idx  = head[EW-1 -: IDX_W];
  assign head_data = head[CHUNK_W-1:0];

  rfl_chunk_fifo #(.W(EW), .DEPTH(CHUNKS)) u_buf (
    .clk(clk), .rst(rst), .push(arrive), .din({in_idx, mem_data}),
    .pop(pop), .dout(head), .avail(avail)
  );

  rfl_wr_port #(.CHUNK_W(CHUNK_W), .IDX_W(IDX_W), .WR_GAP(WR_GAP)) u_wr (
    .clk(clk), .rst(rst), .avail(avail), .head_idx(head_idx), .head_data(head_data),
    .pop(pop), .arr_we(arr_we), .arr_idx(arr_idx), .arr_wdata(arr_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req       <= 1'b0;
      mem_start     <= '0;
      crit_q        <= '0;
      start_q       <= '0;
      mode_q        <= RFL_INORDER;
      rx_cnt        <= '0;
      wr_cnt        <= '0;
      crit_data     <= '0;
      last_wr       <= 1'b0;
      restart_valid <= 1'b0;
      restart_data  <= '0;
      line_valid    <= 1'b0;
      busy          <= 1'b0;
    end else begin
      mem_req       <= accept;
      restart_valid <= 1'b0;
      last_wr       <= pop && (wr_cnt == (IDX_W+1)'(CHUNKS - 1));
      if (accept) begin
        crit_q     <= off_idx;
        start_q    <= cwf_mode ? off_idx : '0;
        mem_start  <= cwf_mode ? off_idx : '0;
        mode_q     <= cwf_mode ? RFL_CRIT : RFL_INORDER;
        rx_cnt     <= '0;
        wr_cnt     <= '0;
        busy       <= 1'b1;
        line_valid <= 1'b0;
      end
      if (arrive) begin
        rx_cnt <= rx_cnt + 1'b1;
        if (in_idx == crit_q) begin
          crit_data <= mem_data;
          if (mode_q == RFL_CRIT) begin
            restart_valid <= 1'b1;
            restart_data  <= mem_data;
          end
        end
      end
      if (pop) wr_cnt <= wr_cnt + 1'b1;
      if (last_wr) begin
        busy       <= 1'b0;
        line_valid <= 1'b1;
        if (mode_q == RFL_INORDER) begin
          restart_valid <= 1'b1;
          restart_data  <= crit_data;
        end
      end
    end
  end
endmodule

// File: rtl/rfl_checker.sv
module rfl_checker #(
  parameter int WR_GAP = 4,
  localparam int SW    = $clog2(WR_GAP + 1)
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic mem_req,
  input logic arr_we,
  input logic restart_valid,
  input logic line_valid
);
  logic [SW-1:0] since_wr;
  logic [1:0]    rs_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr <= SW'(WR_GAP);
      rs_cnt   <= '0;
    end else begin
      if (arr_we) since_wr <= SW'(1);
      else if (since_wr != SW'(WR_GAP)) since_wr <= since_wr + 1'b1;
      if (mem_req) rs_cnt <= '0;
      else if (restart_valid && rs_cnt != 2'd3) rs_cnt <= rs_cnt + 1'b1;
    end
  end

  a_r4_write_gap: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (since_wr == SW'(WR_GAP)));
  a_r8_single_restart: assert property (@(posedge clk) disable iff (rst)
    restart_valid |-> (rs_cnt == 2'd0));
  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (rst)
    restart_valid |=> !restart_valid);
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  a_r7_line_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(line_valid) |-> $past(arr_we));
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> line_valid);
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !arr_we);
endmodule

bind rfl_refill_seq rfl_checker #(.WR_GAP(WR_GAP)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .arr_we(arr_we),
  .restart_valid(restart_valid), .line_valid(line_valid)
);

// File: tb/tb_rfl_refill_seq.sv
module tb_rfl_refill_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic miss_req = 0, cwf_mode = 0, mem_valid = 0;
  logic [5:0] miss_off = '0;
  logic [127:0] mem_data = '0;
  logic mem_req, arr_we, restart_valid, line_valid, busy;
  logic [1:0] mem_start, arr_idx;
  logic [127:0] arr_wdata, restart_data;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  rfl_refill_seq dut (.*);

  function automatic logic [127:0] pat(int n, int idx);
    return {32'(n), 32'(idx), 32'hC0DE_0000 + 32'(idx), ~32'(n * 7 + idx)};
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_miss(int n, bit mode, int crit, int first, int gap, bit poke);
    int start, c, k, nwr, nrs, nreq, last_w, arr_at[4], w_at[4];
    logic [5:0] off;
    off = 6'({crit[1:0], 4'(n)});
    start = mode ? crit : 0;
    for (int j = 0; j < 4; j++) arr_at[j] = first + j * gap + 1;
    w_at[0] = arr_at[0] + 1;
    for (int j = 1; j < 4; j++) w_at[j] = (arr_at[j] + 1 > w_at[j-1] + 4) ? arr_at[j] + 1 : w_at[j-1] + 4;
    last_w = w_at[3];
    miss_req = 1; miss_off = off; cwf_mode = mode;
    @(posedge clk); #1;
    miss_req = 0;
    c = 1; k = 0; nwr = 0; nrs = 0; nreq = 0;
    chk(mem_req && busy && !line_valid, "R2 req/busy/clear", {mem_req, busy, line_valid}, 3'b110);
    chk(mem_start == 2'(start), "R2 start chunk", 128'(mem_start), 128'(start));
    while (c <= last_w + 6) begin
      if (c > 1 && mem_req) nreq++;
      if (arr_we) begin
        if (nwr < 4) begin
          chk(c == w_at[nwr], "R4 write cycle", 128'(c), 128'(w_at[nwr]));
          chk(arr_idx == 2'((start + nwr) % 4), "R3 write index", 128'(arr_idx), 128'((start + nwr) % 4));
          chk(arr_wdata == pat(n, (start + nwr) % 4), "R3 write data", arr_wdata, pat(n, (start + nwr) % 4));
        end
        nwr++;
      end
      if (restart_valid) begin
        nrs++;
        chk(c == (mode ? arr_at[(crit - start + 4) % 4] : last_w + 1),
            mode ? "R5 restart cycle" : "R6 restart cycle", 128'(c),
            128'(mode ? arr_at[(crit - start + 4) % 4] : last_w + 1));
        chk(restart_data == pat(n, crit), mode ? "R5 restart data" : "R6 restart data", restart_data, pat(n, crit));
      end
      if (c == last_w) chk(!line_valid && busy, "R7 line not yet valid", {line_valid, busy}, 2'b01);
      if (c == last_w + 1) chk(line_valid && !busy, "R7 R10 line valid, busy low", {line_valid, busy}, 2'b10);
      // drive inputs for the next edge
      mem_valid = 0;
      if (k < 4 && c == first + k * gap) begin
        mem_valid = 1; mem_data = pat(n, (start + k) % 4); k++;
      end
      miss_req = poke && (c == 3);
      miss_off = ~off;
      @(posedge clk); #1;
      c++;
    end
    mem_valid = 0; miss_req = 0;
    chk(nwr == 4, "R3 write count", 128'(nwr), 128'(4));
    chk(nrs == 1, "R8 restart count", 128'(nrs), 128'(1));
    chk(nreq == 0, "R9 no extra request", 128'(nreq), 128'(0));
    if (poke) begin
      mem_valid = 1; mem_data = pat(n + 99, 0);
      @(posedge clk); #1; mem_valid = 0;
      nwr = 0;
      for (int j = 0; j < 6; j++) begin
        if (arr_we) nwr++;
        @(posedge clk); #1;
      end
      chk(nwr == 0 && line_valid, "R9 idle chunk ignored", {nwr[0], line_valid}, 2'b01);
    end
  endtask

  initial begin
    #(10 * 190000);
    fails++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(!mem_req && !arr_we && !restart_valid && !line_valid && !busy, "R1 reset state",
        {mem_req, arr_we, restart_valid, line_valid, busy}, 5'b0);
    rst = 0;
    @(posedge clk); #1;
    n = 0;
    for (int g = 0; g < 3; g++)
      for (int m = 0; m < 2; m++)
        for (int cr = 0; cr < 4; cr++) begin
          run_miss(n, m[0], cr, (g == 0) ? 120 : 5, (g == 0) ? 16 : ((g == 1) ? 1 : 3), cr == 1);
          n++;
        end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule